// File: doc/BRIEF.md
# Two-Thread Quota Allocator

This block sits between a shared micro-operation queue and the back-end buffers of a core that runs two hardware threads at once. Each cycle it looks at the head micro-op of each thread and picks at most one of them. The chosen micro-op always receives a reorder-buffer slot. A load also receives a load-buffer slot, and a store also receives a store-buffer slot. For each thread the block tracks how many entries of each buffer that thread holds, and it refuses any allocation that would push a thread past its cap.

When both threads can proceed, the block alternates between them. When one thread is out of a resource that its head micro-op needs, that thread is flagged as stalled and the other thread keeps allocating. When only one thread can proceed, that thread is served on every cycle. Entries are returned through per-thread release strobes, one per buffer type. Each release may arrive in the same cycle as an allocation to the same counter.

The per-thread slot index is a ring position inside that thread's share of each buffer. Every result is registered and appears on the outputs one clock after the cycle in which the decision was made. The `accept` strobe is the only combinational output. It pops the chosen thread's queue head in the decision cycle.

Top module: `dual_thread_allocator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `alloc_valid` and both `stall` bits are 0. The first cycle in which both threads are eligible grants thread 0.
- R2: At most one micro-op is granted per cycle, and `accept` is one-hot or zero. A grant decided at one rising edge appears on `alloc_valid`, `alloc_tid` and the index outputs right after that edge.
- R3: Whenever both threads are eligible, the granted thread is the opposite of the thread granted last.
- R4: When exactly one thread is eligible, that thread is granted in that cycle. The next cycle in which both are eligible then grants the other thread.
- R5: Class encoding on `uop_kind`: 2'b00 is plain, 2'b01 is load, 2'b10 is store, and 2'b11 is treated as plain. Every class takes a reorder slot. Only loads take a load slot, and only stores take a store slot. A full store buffer does not block a plain micro-op or a load from the same thread.
- R6: A thread never holds more than 63 reorder-buffer entries. With 63 held, its next micro-op is not granted.
- R7: A thread never holds more than 24 load-buffer entries.
- R8: A thread never holds more than 12 store-buffer entries.
- R9: `stall[t]` is 1 right after an edge at which thread t had a pending micro-op that needed a resource at its cap. In that same cycle an eligible other thread is granted.
- R10: A release and an allocation to the same counter in one cycle both take effect. A release while the count is 0 is ignored. The allocation decision uses the count held before that cycle's release.
- R11: Each thread's slot index for each buffer starts at 0 after reset. It advances by one per slot granted and wraps from cap-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uop_valid | input | 2 | Per thread: a micro-op is pending at the queue head |
| uop_kind | input | 2x2 | Per thread: class of the head micro-op (R5 encoding) |
| accept | output | 2 | Per thread: the head is taken this cycle (combinational) |
| rob_free | input | 2 | Per thread: release one reorder-buffer entry |
| ld_free | input | 2 | Per thread: release one load-buffer entry |
| st_free | input | 2 | Per thread: release one store-buffer entry |
| alloc_valid | output | 1 | Registered allocation strobe |
| alloc_tid | output | 1 | Thread of the registered allocation |
| alloc_kind | output | 2 | Class of the registered allocation |
| rob_idx | output | 6 | Reorder slot index within the thread's share |
| ld_idx | output | 5 | Load slot index (meaningful for loads) |
| st_idx | output | 4 | Store slot index (meaningful for stores) |
| stall | output | 2 | Registered per-thread cap stall flag |

## Verification
On every cycle, the embedded properties check the following:
- No counter ever exceeds its cap.
- A release never drives a count below zero.
- `accept` is never more than one-hot.
- A stalled thread is never reported as allocated.
- The arbiter flips threads whenever both are eligible.
- One thread's stall never starves an eligible partner.

Some behaviours only the bench scenarios can show:
- The exact cap values of 63, 24 and 12.
- Index wrap-around.
- Class-specific blocking.
- A release at zero being ignored.
- A same-cycle release and allocation, observed through the grant on the following cycle.

// File: rtl/talloc_pkg.sv
package talloc_pkg;

  localparam int NTHR = 2;

  typedef enum logic [1:0] {
    UOP_PLAIN = 2'b00,
    UOP_LOAD  = 2'b01,
    UOP_STORE = 2'b10,
    UOP_ALT   = 2'b11
  } uop_kind_e;

  function automatic logic needs_ld(input logic [1:0] k);
    return k == UOP_LOAD;
  endfunction

  function automatic logic needs_st(input logic [1:0] k);
    return k == UOP_STORE;
  endfunction

endpackage

// File: rtl/quota_slot_ctr.sv
module quota_slot_ctr #(
  parameter int CAP = 12,
  localparam int CW = $clog2(CAP + 1),
  localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic          full,
  output logic [IW-1:0] tail
);

  logic [CW-1:0] count;
  logic          take_ok;
  logic          give_ok;

  assign full    = (count == CW'(CAP));
  assign take_ok = take && !full;
  assign give_ok = give && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      tail  <= '0;
    end else begin
      case ({take_ok, give_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (take_ok) begin
        if (tail == IW'(CAP - 1)) tail <= '0;
        else                      tail <= tail + 1'b1;
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(CAP));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !take) |=> (count == '0));

  // R8
  take_at_cap_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> !full);

endmodule

// File: rtl/thread_picker.sv
module thread_picker (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] elig,
  output logic       gnt_valid,
  output logic       gnt_tid
);

  logic ptr;

  always_comb begin
    gnt_valid = |elig;
    if (&elig) gnt_tid = ptr;
    else       gnt_tid = elig[1];
  end

  always_ff @(posedge clk) begin
    if (rst)            ptr <= 1'b0;
    else if (gnt_valid) ptr <= ~gnt_tid;
  end

  // R3
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid ##1 (&elig)) |-> (gnt_tid != $past(gnt_tid)));

  // R4
  single_served_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(elig) |-> (gnt_valid && elig[gnt_tid]));

endmodule

// File: rtl/dual_thread_allocator.sv
module dual_thread_allocator #(
  parameter int ROB_CAP = 63,
  parameter int LD_CAP  = 24,
  parameter int ST_CAP  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 uop_valid,
  input  logic [1:0][1:0]            uop_kind,
  output logic [1:0]                 accept,
  input  logic [1:0]                 rob_free,
  input  logic [1:0]                 ld_free,
  input  logic [1:0]                 st_free,
  output logic                       alloc_valid,
  output logic                       alloc_tid,
  output logic [1:0]                 alloc_kind,
  output logic [$clog2(ROB_CAP)-1:0] rob_idx,
  output logic [$clog2(LD_CAP)-1:0]  ld_idx,
  output logic [$clog2(ST_CAP)-1:0]  st_idx,
  output logic [1:0]                 stall
);
  import talloc_pkg::*;

  localparam int ROB_IW = $clog2(ROB_CAP);
  localparam int LD_IW  = $clog2(LD_CAP);
  localparam int ST_IW  = $clog2(ST_CAP);

  logic [NTHR-1:0] rob_full, ld_full, st_full;
  logic [NTHR-1:0] blocked, elig;
  logic [ROB_IW-1:0] rob_tail [NTHR];
  logic [LD_IW-1:0]  ld_tail  [NTHR];
  logic [ST_IW-1:0]  st_tail  [NTHR];
  logic gnt_valid, gnt_tid;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic wants_ld, wants_st;

    assign wants_ld   = needs_ld(uop_kind[t]);
    assign wants_st   = needs_st(uop_kind[t]);
    assign blocked[t] = rob_full[t] || (wants_ld && ld_full[t]) ||
                        (wants_st && st_full[t]);
    assign elig[t]    = uop_valid[t] && !blocked[t];
    assign accept[t]  = gnt_valid && (gnt_tid == 1'(t));

    quota_slot_ctr #(.CAP(ROB_CAP)) u_rob (
      .clk(clk), .rst(rst), .take(accept[t]), .give(rob_free[t]),
      .full(rob_full[t]), .tail(rob_tail[t]));

    quota_slot_ctr #(.CAP(LD_CAP)) u_ld (
      .clk(clk), .rst(rst), .take(accept[t] && wants_ld), .give(ld_free[t]),
      .full(ld_full[t]), .tail(ld_tail[t]));

    quota_slot_ctr #(.CAP(ST_CAP)) u_st (
      .clk(clk), .rst(rst), .take(accept[t] && wants_st), .give(st_free[t]),
      .full(st_full[t]), .tail(st_tail[t]));
  end

  thread_picker u_pick (
    .clk(clk), .rst(rst), .elig(elig),
    .gnt_valid(gnt_valid), .gnt_tid(gnt_tid));

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_valid <= 1'b0;
      alloc_tid   <= 1'b0;
      alloc_kind  <= 2'b00;
      rob_idx     <= '0;
      ld_idx      <= '0;
      st_idx      <= '0;
      stall       <= '0;
    end else begin
      alloc_valid <= gnt_valid;
      alloc_tid   <= gnt_tid;
      alloc_kind  <= uop_kind[gnt_tid];
      rob_idx     <= rob_tail[gnt_tid];
      ld_idx      <= ld_tail[gnt_tid];
      st_idx      <= st_tail[gnt_tid];
      stall       <= uop_valid & blocked;
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(accept));

  // R9
  stall_not_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> !stall[alloc_tid]);

  // R9
  starve_free_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid[0] && blocked[0] && elig[1]) |-> accept[1]);

  // R9
  starve_free_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid[1] && blocked[1] && elig[0]) |-> accept[0]);

endmodule

// File: tb/dual_thread_allocator_test.sv
`timescale 1ns/1ps
module dual_thread_allocator_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] uop_valid = '0;
  logic [1:0][1:0] uop_kind = '0;
  logic [1:0] accept;
  logic [1:0] rob_free = '0, ld_free = '0, st_free = '0;
  logic alloc_valid, alloc_tid;
  logic [1:0] alloc_kind;
  logic [5:0] rob_idx;
  logic [4:0] ld_idx;
  logic [3:0] st_idx;
  logic [1:0] stall;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_thread_allocator uut (
    .clk(clk), .rst(rst), .uop_valid(uop_valid), .uop_kind(uop_kind),
    .accept(accept), .rob_free(rob_free), .ld_free(ld_free), .st_free(st_free),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_kind(alloc_kind),
    .rob_idx(rob_idx), .ld_idx(ld_idx), .st_idx(st_idx), .stall(stall));

  // {v0, kind0[1:0], v1, kind1[1:0], expected valid, expected tid}
  localparam logic [7:0] VEC [10] = '{
    8'b1_00_1_00_1_0, 8'b1_00_1_00_1_1, 8'b1_01_1_10_1_0, 8'b0_00_1_00_1_1,
    8'b0_00_1_11_1_1, 8'b1_10_1_00_1_0, 8'b0_00_0_00_0_0, 8'b1_01_0_00_1_0,
    8'b1_00_1_01_1_1, 8'b1_10_1_10_1_0
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; uop_valid = '0; uop_kind = '0;
    rob_free = '0; ld_free = '0; st_free = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic expect_grant(input logic tid, input string req);
    check(alloc_valid == 1'b1, req, int'(alloc_valid), 1);
    check(alloc_tid == tid, req, int'(alloc_tid), int'(tid));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check(alloc_valid == 1'b0, "R1", int'(alloc_valid), 0);
    check(stall == 2'b00, "R1", int'(stall), 0);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < 10; i++) begin
      uop_valid[0] = VEC[i][7]; uop_kind[0] = VEC[i][6:5];
      uop_valid[1] = VEC[i][4]; uop_kind[1] = VEC[i][3:2];
      step();
      check(alloc_valid == VEC[i][1], "R3/R4 valid", int'(alloc_valid), int'(VEC[i][1]));
      if (VEC[i][1]) check(alloc_tid == VEC[i][0], "R3/R4 tid", int'(alloc_tid), int'(VEC[i][0]));
      check(stall == 2'b00, "R9 no stall", int'(stall), 0);
    end

    // R8 store cap, R11 index sequence
    do_reset();
    uop_valid = 2'b01; uop_kind[0] = 2'b10;
    for (int i = 0; i < 12; i++) begin
      step();
      expect_grant(1'b0, "R8");
      check(st_idx == 4'(i), "R11 st_idx", int'(st_idx), i);
    end
    uop_valid = 2'b11; uop_kind[1] = 2'b11;
    step();
    expect_grant(1'b1, "R9 other thread proceeds");
    check(stall == 2'b01, "R9 stall t0", int'(stall), 1);
    // R5 a load from thread 0 is not blocked by full store buffer
    uop_valid = 2'b01; uop_kind[0] = 2'b01;
    step();
    expect_grant(1'b0, "R5 load past store cap");
    check(ld_idx == 5'd0, "R5 ld_idx", int'(ld_idx), 0);
    // R10 release decided on old count, then wrap
    uop_kind[0] = 2'b10; st_free[0] = 1'b1;
    step();
    check(alloc_valid == 1'b0, "R10 old count used", int'(alloc_valid), 0);
    check(stall[0] == 1'b1, "R9 stall held", int'(stall[0]), 1);
    st_free[0] = 1'b0;
    step();
    expect_grant(1'b0, "R10 after release");
    check(st_idx == 4'd0, "R11 wrap", int'(st_idx), 0);

    // R7 load cap, R10 release at zero ignored
    do_reset();
    ld_free[1] = 1'b1;
    repeat (3) begin
      step();
      check(alloc_valid == 1'b0, "R10 idle", int'(alloc_valid), 0);
    end
    ld_free[1] = 1'b0;
    uop_valid = 2'b10; uop_kind[1] = 2'b01;
    for (int i = 0; i < 24; i++) begin
      step();
      expect_grant(1'b1, "R7");
      check(ld_idx == 5'(i), "R11 ld_idx", int'(ld_idx), i);
    end
    step();
    check(alloc_valid == 1'b0, "R7 cap", int'(alloc_valid), 0);
    check(stall == 2'b10, "R7 stall t1", int'(stall), 2);

    // R6 reorder cap, R10 same-cycle release and allocation
    do_reset();
    uop_valid = 2'b01; uop_kind[0] = 2'b00;
    for (int i = 0; i < 62; i++) begin
      step();
      if (alloc_valid != 1'b1 || rob_idx != 6'(i))
        check(1'b0, "R6 fill", int'(rob_idx), i);
    end
    check(rob_idx == 6'd61, "R11 rob_idx", int'(rob_idx), 61);
    rob_free[0] = 1'b1;
    step();
    expect_grant(1'b0, "R10 both applied");
    check(rob_idx == 6'd62, "R11 rob_idx top", int'(rob_idx), 62);
    rob_free[0] = 1'b0;
    step();
    expect_grant(1'b0, "R6 last slot");
    check(rob_idx == 6'd0, "R11 rob wrap", int'(rob_idx), 0);
    step();
    check(alloc_valid == 1'b0, "R6 cap", int'(alloc_valid), 0);
    check(stall == 2'b01, "R6 stall t0", int'(stall), 1);

    // R1 after reset, both eligible grants thread 0 first
    do_reset();
    uop_valid = 2'b11; uop_kind = '0;
    step();
    expect_grant(1'b0, "R1 first grant");
    check(rob_idx == 6'd0, "R11 reset index", int'(rob_idx), 0);

    summary();
    $finish;
  end

endmodule